// File: doc/BRIEF.md
# System Power State Controller

This block tracks the power state of a whole platform. It holds one of eight states: full-on working, working-idle, light sleep (S1), suspend-to-RAM (S3), suspend-to-disk (S4), soft-off (S5), deep soft-off, and mechanical-off (G3). Its inputs are requests from firmware and the processor, and level and pulse signals from the board. From these it works out which state comes next. It drives the active-low rail-off lines that tell the regulators how deep the platform sleeps.

Wake sources are recorded in a sticky status vector. A wake is taken once a recorded source is also enabled. Loss of power beats every other trigger. When power returns, the block reboots or stays off. The choice comes from a policy bit and from whether the platform was working when power was lost. Chosen status bits survive the outage, so a wake recorded before the outage still wakes the platform after power returns. In a mobile configuration, a low battery holds off every entry into the working state from a sleep state or from G3.

Top module: `pwr_state_ctrl`

## Requirements
- R1: Reset puts the block in the working state with all three rail-off lines high and the wake status all zero. The state codes are: 0 working, 1 working-idle, 2 S1, 3 S3, 4 S4, 5 S5, 6 deep soft-off, 7 G3.
- R2: The asynchronous inputs pass through two flip-flops before use. The block acts only on a rising edge of the sleep-enable and override inputs, so a level held high does not trigger again. A rising edge of either input changes the state on the third clock edge after the input changes.
- R3: In the working state, a sleep-enable edge selects the target from the 3-bit sleep type: 001 gives S1, 101 gives S3, 110 gives S4, and 111 or any other nonzero value gives S5. A value of 000 is ignored.
- R4: The idle-entry and idle-exit strobes are synchronous and take effect at the next clock edge. Entry moves working to working-idle. Exit moves working-idle back to working.
- R5: An override edge moves working, working-idle, S1, S3 and S4 to S5. An override has no effect in S5, in deep soft-off or in G3.
- R6: While the synchronized power-good input is low, the next state is G3 from any state. This trigger outranks every other trigger.
- R7: In the sleep states (codes 2 to 6), each synchronized wake input bit sets its bit in the sticky status. When status AND enable is nonzero, the block moves to working on the next edge and clears the status.
- R8: On power return, G3 leaves for working if the policy bit is 0 and the state before the outage was working or working-idle. Otherwise G3 leaves for S5.
- R9: On entry to G3, status bits outside the keep mask (default 0011) are cleared and bits inside it are kept. No wake input is recorded while in G3. A kept bit that is also enabled causes a wake once the block has returned to S5.
- R10: With the mobile strap high and battery-low high, every move into working from codes 2 to 7 is held off. The move completes on the first edge at which the synchronized battery-low is low. Without the strap, battery-low has no effect.
- R11: With the deep strap high, S5 with no pending wake moves to deep soft-off on the next edge. An enabled wake leaves deep soft-off for working.
- R12: S3-rail-off is low in codes 3 to 7. S4-rail-off is low in codes 4 to 7. S5-rail-off is low in codes 5 to 7.
- R13: When triggers coincide, the priority is: power failure first, then override, then sleep-enable or wake, then idle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| idle_enter | input | 1 | synchronous idle-entry strobe |
| idle_exit | input | 1 | synchronous idle-exit strobe |
| slp_en | input | 1 | sleep-enable request, edge-triggered |
| slp_type | input | 3 | requested sleep depth |
| pwr_btn_ovr | input | 1 | power-button override, edge-triggered |
| pwr_good | input | 1 | high while main power is good |
| wake_evt | input | WAKE_W | wake source levels |
| wake_en | input | WAKE_W | wake enable mask |
| batt_low | input | 1 | battery-low level |
| mobile_cfg | input | 1 | mobile configuration strap |
| deep_off_en | input | 1 | allow deep soft-off |
| g3_policy | input | 1 | 1 = stay off after power return |
| pwr_state | output | 3 | current state code |
| s3_off_n | output | 1 | S3 rail-off, active low |
| s4_off_n | output | 1 | S4 rail-off, active low |
| s5_off_n | output | 1 | S5 rail-off, active low |
| wake_sts | output | WAKE_W | sticky wake status |

## Verification
The state code, the rail-off lines and the wake status are all outputs. A wrong next-state choice therefore shows up at the pins on the clock edge where it happens. A wrong stored state shows up later: the record of whether the platform was working before an outage, or the set of kept status bits, only appears when power returns or when the wake mask is changed. The reference model runs in step with the design and compares all outputs on every cycle. Because of this, a fault in an outage path shows up in the first cycle after the return. It does not have to wait for a later symptom.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    ST_ON   = 3'd0,
    ST_IDLE = 3'd1,
    ST_SL1  = 3'd2,
    ST_SL3  = 3'd3,
    ST_SL4  = 3'd4,
    ST_OFF  = 3'd5,
    ST_DOFF = 3'd6,
    ST_MOFF = 3'd7
  } pstate_t;

  // decode of a nonzero sleep-type request
  function automatic pstate_t sleep_target(input logic [2:0] kind);
    case (kind)
      3'b001:  return ST_SL1;
      3'b101:  return ST_SL3;
      3'b110:  return ST_SL4;
      default: return ST_OFF;
    endcase
  endfunction

  function automatic logic is_asleep(input pstate_t s);
    return (s == ST_SL1) || (s == ST_SL3) || (s == ST_SL4) ||
           (s == ST_OFF) || (s == ST_DOFF);
  endfunction

  function automatic logic is_working(input pstate_t s);
    return (s == ST_ON) || (s == ST_IDLE);
  endfunction

  // where the block goes when power comes back
  function automatic pstate_t restart_target(input logic stay_off, input logic was_working);
    return (!stay_off && was_working) ? ST_ON : ST_OFF;
  endfunction

  // {s5_off_n, s4_off_n, s3_off_n}
  function automatic logic [2:0] rail_lines(input pstate_t s);
    logic [2:0] r;
    r = 3'b111;
    case (s)
      ST_SL3:                    r = 3'b110;
      ST_SL4:                    r = 3'b100;
      ST_OFF, ST_DOFF, ST_MOFF:  r = 3'b000;
      default:                   r = 3'b111;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= RST_VAL;
      sync_out <= RST_VAL;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/pwr_edge.sv
module pwr_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= lvl[i];
    end
    assign hit[i] = lvl[i] & ~last_q;
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm import pwr_state_pkg::*; #(
  parameter int WAKE_W = 4,
  parameter logic [WAKE_W-1:0] KEEP_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_ok,
  input  logic              pbo_hit,
  input  logic              slp_hit,
  input  logic [2:0]        slp_kind,
  input  logic              idle_in,
  input  logic              idle_out,
  input  logic [WAKE_W-1:0] wake_lvl,
  input  logic [WAKE_W-1:0] wake_mask,
  input  logic              hold_off,
  input  logic              deep_ok,
  input  logic              stay_off,
  output pstate_t           cur,
  output logic [WAKE_W-1:0] sts,
  output logic              wake_pend
);
  pstate_t nxt;
  pstate_t g3_tgt;
  logic    was_work_q;
  logic    go_moff;
  logic    go_on;

  assign wake_pend = |(sts & wake_mask);
  assign g3_tgt    = restart_target(stay_off, was_work_q);

  always_comb begin
    nxt = cur;
    if (!pg_ok) begin
      nxt = ST_MOFF;
    end else begin
      case (cur)
        ST_ON: begin
          if (pbo_hit)                          nxt = ST_OFF;
          else if (slp_hit && slp_kind != 3'b0) nxt = sleep_target(slp_kind);
          else if (idle_in)                     nxt = ST_IDLE;
        end
        ST_IDLE: begin
          if (pbo_hit)       nxt = ST_OFF;
          else if (idle_out) nxt = ST_ON;
        end
        ST_SL1, ST_SL3, ST_SL4: begin
          if (pbo_hit)                    nxt = ST_OFF;
          else if (wake_pend && !hold_off) nxt = ST_ON;
        end
        ST_OFF: begin
          if (wake_pend) begin
            if (!hold_off) nxt = ST_ON;
          end else if (deep_ok) begin
            nxt = ST_DOFF;
          end
        end
        ST_DOFF: begin
          if (wake_pend && !hold_off) nxt = ST_ON;
        end
        ST_MOFF: begin
          if (!(g3_tgt == ST_ON && hold_off)) nxt = g3_tgt;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  assign go_moff = (nxt == ST_MOFF) && (cur != ST_MOFF);
  assign go_on   = (nxt == ST_ON) && (cur != ST_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= ST_ON;
      sts        <= '0;
      was_work_q <= 1'b1;
    end else begin
      cur <= nxt;
      if (go_moff) begin
        sts        <= sts & KEEP_MASK;
        was_work_q <= is_working(cur);
      end else if (go_on) begin
        sts <= '0;
      end else if (is_asleep(cur)) begin
        sts <= sts | wake_lvl;
      end
    end
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl import pwr_state_pkg::*; #(
  parameter int WAKE_W = 4,
  parameter logic [WAKE_W-1:0] KEEP_MASK = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_enter,
  input  logic              idle_exit,
  input  logic              slp_en,
  input  logic [2:0]        slp_type,
  input  logic              pwr_btn_ovr,
  input  logic              pwr_good,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic              batt_low,
  input  logic              mobile_cfg,
  input  logic              deep_off_en,
  input  logic              g3_policy,
  output logic [2:0]        pwr_state,
  output logic              s3_off_n,
  output logic              s4_off_n,
  output logic              s5_off_n,
  output logic [WAKE_W-1:0] wake_sts
);
  localparam int ASY_W = 2 * WAKE_W + 9;

  logic [ASY_W-1:0]  asy_bus;
  logic [ASY_W-1:0]  syn_bus;
  logic              pbo_s, slp_s, bl_s, mob_s, deep_s, pol_s, pg_s;
  logic [2:0]        type_s;
  logic [WAKE_W-1:0] wake_s, wen_s;
  logic              pbo_p, slp_p;
  logic              defer;
  logic              wake_pend;
  pstate_t           st;

  assign asy_bus = {pwr_btn_ovr, slp_en, slp_type, batt_low, mobile_cfg,
                    deep_off_en, g3_policy, wake_evt, wake_en};

  pwr_sync #(.W(ASY_W), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .async_in(asy_bus), .sync_out(syn_bus)
  );

  pwr_sync #(.W(1), .RST_VAL(1'b1)) u_sync_pg (
    .clk(clk), .rst_n(rst_n), .async_in(pwr_good), .sync_out(pg_s)
  );

  assign {pbo_s, slp_s, type_s, bl_s, mob_s, deep_s, pol_s, wake_s, wen_s} = syn_bus;

  pwr_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({pbo_s, slp_s}), .hit({pbo_p, slp_p})
  );

  assign defer = mob_s & bl_s;

  pwr_fsm #(.WAKE_W(WAKE_W), .KEEP_MASK(KEEP_MASK)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pg_ok(pg_s), .pbo_hit(pbo_p), .slp_hit(slp_p),
    .slp_kind(type_s), .idle_in(idle_enter), .idle_out(idle_exit),
    .wake_lvl(wake_s), .wake_mask(wen_s), .hold_off(defer), .deep_ok(deep_s),
    .stay_off(pol_s), .cur(st), .sts(wake_sts), .wake_pend(wake_pend)
  );

  assign pwr_state = st;
  assign {s5_off_n, s4_off_n, s3_off_n} = rail_lines(st);
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk import pwr_state_pkg::*; #(
  parameter int WAKE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_s,
  input logic              pbo_p,
  input logic              defer,
  input logic              wake_pend,
  input logic [2:0]        st,
  input logic [WAKE_W-1:0] sts,
  input logic              s3_off_n,
  input logic              s4_off_n,
  input logic              s5_off_n
);
  p_pfail_g3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> st == ST_MOFF);

  p_pbo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_s && pbo_p && (st == ST_ON || st == ST_IDLE || st == ST_SL1 ||
                       st == ST_SL3 || st == ST_SL4)) |=> st == ST_OFF);

  p_off_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_s && (st == ST_OFF || st == ST_DOFF)) |=>
      (st == ST_OFF || st == ST_DOFF || st == ST_ON));

  p_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_s && defer && st != ST_ON && st != ST_IDLE) |=> st != ST_ON);

  p_g3_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_s && st == ST_MOFF) |=> (st == ST_ON || st == ST_OFF || st == ST_MOFF));

  p_g3_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MOFF) |=> (st == ST_ON || $stable(sts)));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_s && !pbo_p && wake_pend && !defer &&
     (st == ST_SL1 || st == ST_SL3 || st == ST_SL4 || st == ST_OFF || st == ST_DOFF))
      |=> (st == ST_ON && sts == '0));

  p_rail_nest_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!s5_off_n |-> !s4_off_n) and (!s4_off_n |-> !s3_off_n));
endmodule

bind pwr_state_ctrl pwr_state_chk #(.WAKE_W(WAKE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .pbo_p(pbo_p), .defer(defer),
  .wake_pend(wake_pend), .st(pwr_state), .sts(wake_sts),
  .s3_off_n(s3_off_n), .s4_off_n(s4_off_n), .s5_off_n(s5_off_n)
);

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;
  localparam int W = 4;
  localparam logic [W-1:0] KEEP = 4'b0011;

  logic clk = 0, rst_n = 0;
  logic idle_enter = 0, idle_exit = 0, slp_en = 0, pwr_btn_ovr = 0, pwr_good = 1;
  logic [2:0] slp_type = 0;
  logic [W-1:0] wake_evt = 0, wake_en = 0;
  logic batt_low = 0, mobile_cfg = 0, deep_off_en = 0, g3_policy = 0;
  logic [2:0] pwr_state;
  logic s3_off_n, s4_off_n, s5_off_n;
  logic [W-1:0] wake_sts;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pwr_state_ctrl #(.WAKE_W(W), .KEEP_MASK(KEEP)) u_dut (.*);

  // reference model state and its own three-stage input history
  int m_st = 0;
  logic [W-1:0] m_sts = 0;
  bit m_prevw = 1;
  bit pbo1 = 0, pbo2 = 0, pbo3 = 0, sl1 = 0, sl2 = 0, sl3 = 0;
  bit pg1 = 1, pg2 = 1, bl1 = 0, bl2 = 0, mo1 = 0, mo2 = 0;
  bit dp1 = 0, dp2 = 0, po1 = 0, po2 = 0;
  logic [2:0] ty1 = 0, ty2 = 0;
  logic [W-1:0] we1 = 0, we2 = 0, en1 = 0, en2 = 0;

  function automatic int decode(input logic [2:0] t);
    if (t == 3'b001) return 2;
    if (t == 3'b101) return 3;
    if (t == 3'b110) return 4;
    return 5;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sts = 0; m_prevw = 1;
      pbo1 = 0; pbo2 = 0; pbo3 = 0; sl1 = 0; sl2 = 0; sl3 = 0;
      pg1 = 1; pg2 = 1; bl1 = 0; bl2 = 0; mo1 = 0; mo2 = 0;
      dp1 = 0; dp2 = 0; po1 = 0; po2 = 0; ty1 = 0; ty2 = 0;
      we1 = 0; we2 = 0; en1 = 0; en2 = 0;
    end else begin
      bit pb, sp, pend, hold;
      int nx;
      pb = pbo2 && !pbo3;
      sp = sl2 && !sl3;
      pend = (m_sts & en2) != 0;
      hold = mo2 && bl2;
      nx = m_st;
      if (!pg2) nx = 7;
      else if (m_st == 7) nx = (!po2 && m_prevw) ? 0 : 5;
      else if (m_st == 0) begin
        if (pb) nx = 5;
        else if (sp && ty2 != 0) nx = decode(ty2);
        else if (idle_enter) nx = 1;
      end else if (m_st == 1) begin
        if (pb) nx = 5;
        else if (idle_exit) nx = 0;
      end else if (m_st <= 4) begin
        if (pb) nx = 5;
        else if (pend) nx = 0;
      end else if (m_st == 5) begin
        if (pend) nx = 0;
        else if (dp2) nx = 6;
      end else if (pend) nx = 0;
      if (nx == 0 && m_st >= 2 && hold) nx = m_st;
      if (nx == 7 && m_st != 7) begin
        m_sts = m_sts & KEEP;
        m_prevw = (m_st <= 1);
      end else if (nx == 0 && m_st != 0) m_sts = 0;
      else if (m_st >= 2 && m_st <= 6) m_sts = m_sts | we2;
      m_st = nx;
      pbo3 = pbo2; pbo2 = pbo1; pbo1 = pwr_btn_ovr;
      sl3 = sl2; sl2 = sl1; sl1 = slp_en;
      pg2 = pg1; pg1 = pwr_good; bl2 = bl1; bl1 = batt_low;
      mo2 = mo1; mo1 = mobile_cfg; dp2 = dp1; dp1 = deep_off_en;
      po2 = po1; po1 = g3_policy; ty2 = ty1; ty1 = slp_type;
      we2 = we1; we1 = wake_evt; en2 = en1; en1 = wake_en;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [2:0] rails;
      rails = {~(m_st >= 5), ~(m_st >= 4), ~(m_st >= 3)};
      total++;
      if (pwr_state !== 3'(m_st) || wake_sts !== m_sts ||
          {s5_off_n, s4_off_n, s3_off_n} !== rails) begin
        bad++;
        $display("FAIL %s model: state=%0d sts=%b rails=%b exp state=%0d sts=%b rails=%b",
                 cur_req, pwr_state, wake_sts, {s5_off_n, s4_off_n, s3_off_n},
                 m_st, m_sts, rails);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp=fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input int code, input string tag);
    total++;
    if (pwr_state !== 3'(code)) begin
      bad++;
      $display("FAIL %s: state act=%0d exp=%0d", tag, pwr_state, code);
    end
  endtask

  task automatic expect_sts(input logic [W-1:0] v, input string tag);
    total++;
    if (wake_sts !== v) begin
      bad++;
      $display("FAIL %s: wake_sts act=%b exp=%b", tag, wake_sts, v);
    end
  endtask

  task automatic expect_rails(input logic [2:0] v, input string tag);
    total++;
    if ({s5_off_n, s4_off_n, s3_off_n} !== v) begin
      bad++;
      $display("FAIL %s: rails act=%b exp=%b", tag, {s5_off_n, s4_off_n, s3_off_n}, v);
    end
  endtask

  task automatic wake_pulse(input logic [W-1:0] v);
    wake_evt = v; tick(2); wake_evt = 0; tick(5);
  endtask

  task automatic go_sleep(input logic [2:0] t);
    slp_type = t; slp_en = 1; tick(4); slp_en = 0; tick(3);
  endtask

  initial begin
    tick(3);
    cur_req = "R1";
    expect_st(0, "R1 reset state");
    expect_rails(3'b111, "R1 reset rails");
    expect_sts(0, "R1 reset status");
    rst_n = 1;
    tick(2);
    wake_en = 4'b0001;

    cur_req = "R2";
    slp_type = 3'b101; slp_en = 1;
    tick(2); expect_st(0, "R2 not before third edge");
    tick(1); expect_st(3, "R2 third edge");
    tick(6); expect_st(3, "R2 held level no retrigger");
    slp_en = 0; tick(3);
    cur_req = "R7";
    wake_pulse(4'b0001);
    expect_st(0, "R7 wake to working");
    expect_sts(0, "R7 status cleared");

    cur_req = "R3";
    for (int t = 0; t < 8; t++) begin
      int e;
      e = (t == 0) ? 0 : decode(3'(t));
      go_sleep(3'(t));
      expect_st(e, "R3 sleep type decode");
      if (t == 6) expect_rails(3'b100, "R12 rails in S4");
      if (t == 5) expect_rails(3'b110, "R12 rails in S3");
      if (e != 0) begin
        wake_pulse(4'b0001);
        expect_st(0, "R3 back to working");
      end
    end

    cur_req = "R4";
    idle_enter = 1; tick(1); idle_enter = 0;
    expect_st(1, "R4 idle entry");
    idle_exit = 1; tick(1); idle_exit = 0;
    expect_st(0, "R4 idle exit");

    cur_req = "R5";
    idle_enter = 1; tick(1); idle_enter = 0;
    pwr_btn_ovr = 1; tick(4); pwr_btn_ovr = 0;
    expect_st(5, "R5 override from idle");
    tick(3);
    pwr_btn_ovr = 1; tick(4); pwr_btn_ovr = 0; tick(3);
    expect_st(5, "R5 override ignored in S5");
    wake_pulse(4'b0001);
    expect_st(0, "R5 wake after override");

    cur_req = "R13";
    slp_type = 3'b001; slp_en = 1; pwr_btn_ovr = 1;
    tick(4); slp_en = 0; pwr_btn_ovr = 0;
    expect_st(5, "R13 override beats sleep");
    tick(3); wake_pulse(4'b0001);
    slp_type = 3'b001; slp_en = 1; tick(2);
    idle_enter = 1; tick(1); idle_enter = 0;
    expect_st(2, "R13 sleep beats idle strobe");
    slp_en = 0; tick(3); wake_pulse(4'b0001);

    cur_req = "R9";
    wake_en = 0; tick(3);
    go_sleep(3'b101);
    wake_pulse(4'b0101);
    expect_sts(4'b0101, "R7 status recorded without enable");
    expect_st(3, "R7 no wake without enable");
    cur_req = "R6";
    pwr_good = 0; tick(4);
    expect_st(7, "R6 power failure to G3");
    expect_rails(3'b000, "R12 rails in G3");
    cur_req = "R9";
    expect_sts(4'b0001, "R9 kept bits only");
    wake_pulse(4'b1000);
    expect_sts(4'b0001, "R9 no recording in G3");
    cur_req = "R8";
    pwr_good = 1; tick(4);
    expect_st(5, "R8 return to S5 after sleep");
    cur_req = "R9";
    wake_en = 4'b0001; tick(4);
    expect_st(0, "R9 kept bit wakes");

    cur_req = "R8";
    pwr_good = 0; tick(4); pwr_good = 1; tick(4);
    expect_st(0, "R8 reboot with policy 0");
    g3_policy = 1; tick(3);
    pwr_good = 0; tick(4); pwr_good = 1; tick(4);
    expect_st(5, "R8 stay off with policy 1");
    g3_policy = 0; wake_pulse(4'b0001);
    expect_st(0, "R8 wake after stay off");

    cur_req = "R10";
    mobile_cfg = 1; batt_low = 1; tick(3);
    go_sleep(3'b001);
    wake_pulse(4'b0001); tick(3);
    expect_st(2, "R10 wake held off");
    batt_low = 0; tick(2);
    expect_st(2, "R10 still held before sync");
    tick(1);
    expect_st(0, "R10 first cycle after release");
    mobile_cfg = 0; batt_low = 1; tick(3);
    go_sleep(3'b001);
    wake_pulse(4'b0001);
    expect_st(0, "R10 no effect without strap");
    batt_low = 0; tick(3);

    cur_req = "R11";
    deep_off_en = 1; tick(3);
    pwr_btn_ovr = 1; tick(3);
    expect_st(5, "R11 S5 first");
    tick(1);
    expect_st(6, "R11 deep entry");
    expect_rails(3'b000, "R12 rails in deep off");
    pwr_btn_ovr = 0; tick(3);
    pwr_btn_ovr = 1; tick(4); pwr_btn_ovr = 0; tick(3);
    expect_st(6, "R5 override ignored in deep off");
    wake_pulse(4'b0001);
    expect_st(0, "R11 wake from deep off");
    deep_off_en = 0; tick(3);

    cur_req = "R6";
    pwr_good = 0; pwr_btn_ovr = 1; tick(4);
    expect_st(7, "R6 failure beats override");
    pwr_btn_ovr = 0; pwr_good = 1; tick(4);
    expect_st(0, "R8 reboot from working");
    tick(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule